// File: doc/BRIEF.md
# Pause Flow Control Resolver

This block settles how a full-duplex Ethernet MAC handles pause frames once link auto-negotiation has finished. It takes the pause and asymmetric-direction abilities advertised by the local port and by the link partner, the requested flow-control mode and the negotiated duplex. From these it chooses one of four modes: none, receive pause only, transmit pause only, or both. From that mode it drives the MAC's transmit-pause and receive-pause enables and the receive FIFO low and high threshold words.

A resolution is armed by the rising edge of the auto-negotiation-complete flag. All outputs load together on that edge and then hold, whatever the inputs do, until the flag falls and rises again. One cycle after the outputs load, a single-cycle done pulse tells the surrounding logic that the new settings are in place. Reading the PHY registers and building pause frames are left to other blocks.

Top module: `pause_fc_resolver`

## Requirements
- R1: After reset every output is zero: mode 0, both enables low, both threshold words zero, done low.
- R2: The mode output is encoded 0 = none, 1 = receive pause only, 2 = transmit pause only, 3 = both. When local and partner both advertise pause, the mode is 3 if the requested code is 3 (full) or 4 to 7 (default, treated as full), and 1 for requested codes 0, 1 or 2.
- R3: Local pause 0 with local asym 1, against partner pause 1 with partner asym 1, gives mode 2.
- R4: Local pause 1 with local asym 1, against partner pause 0 with partner asym 1, gives mode 1.
- R5: Every ability combination not covered by R2 to R4 gives mode 0.
- R6: When full_duplex is low at resolution, the mode is 0 whatever the abilities and request.
- R7: tx_pause_en is high exactly for modes 2 and 3; rx_pause_en is high exactly for modes 1 and 3.
- R8: When the resolved mode has transmit pause (2 or 3), the threshold words carry low_water and high_water zero-extended in their low bits. Otherwise both words are zero.
- R9: Bit 31 of the low threshold word is set when send_xon is high and transmit pause is enabled, and is clear otherwise.
- R10: Outputs update only on the cycle that an_done is seen rising. While an_done stays high or stays low, input changes leave every output unchanged.
- R11: resolve_done is high for exactly one cycle, the cycle after the outputs load, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| an_done | input | 1 | Auto-negotiation complete; rising edge triggers resolution |
| loc_pause | input | 1 | Local pause ability advertised |
| loc_asym | input | 1 | Local asymmetric-direction ability advertised |
| lp_pause | input | 1 | Partner pause ability |
| lp_asym | input | 1 | Partner asymmetric-direction ability |
| full_duplex | input | 1 | 1 = full duplex link, 0 = half duplex |
| req_mode | input | 3 | Requested mode: 0 none, 1 rx, 2 tx, 3 full, 4 to 7 default |
| low_water | input | 16 | Low water mark value |
| high_water | input | 16 | High water mark value |
| send_xon | input | 1 | Request XON frames when the low threshold is crossed |
| fc_mode | output | 2 | Resolved mode |
| tx_pause_en | output | 1 | Transmit pause enable |
| rx_pause_en | output | 1 | Receive pause enable |
| fc_low_thr | output | 32 | Low threshold word, XON enable in bit 31 |
| fc_high_thr | output | 32 | High threshold word |
| resolve_done | output | 1 | One-cycle pulse after the outputs load |

## Verification
The bench goes after the both-pause case under every request code. A design that forgot the downgrade would report full when only receive was asked for, and one that treated codes 4 to 7 as unknown would report receive-only. It walks the asymmetric cases one bit away from the two transmit-only and receive-only rows, where a loose decode would grant pause that the table denies. It also checks half-duplex links that advertise full symmetric pause, which must still come out as none with zero thresholds. Finally it holds an_done high while changing inputs, which catches a level-triggered design that keeps re-resolving or a done flag that stays high.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_RX   = 2'd1,
    FC_TX   = 2'd2,
    FC_FULL = 2'd3
  } fc_mode_e;

  localparam logic [2:0] REQ_FULL = 3'd3;

  // Full is granted for the explicit full request and for every default code.
  function automatic logic wants_full(input logic [2:0] req);
    return (req == REQ_FULL) || req[2];
  endfunction

  function automatic fc_mode_e resolve_pause(
    input logic       lp, input logic la,
    input logic       rp, input logic ra,
    input logic       fd, input logic [2:0] req
  );
    fc_mode_e m;
    if (lp && rp)                 m = wants_full(req) ? FC_FULL : FC_RX;
    else if (!lp && la && rp && ra) m = FC_TX;
    else if (lp && la && !rp && ra) m = FC_RX;
    else                          m = FC_NONE;
    if (!fd) m = FC_NONE;
    return m;
  endfunction

  function automatic logic mode_has_tx(input fc_mode_e m);
    return (m == FC_TX) || (m == FC_FULL);
  endfunction

  function automatic logic mode_has_rx(input fc_mode_e m);
    return (m == FC_RX) || (m == FC_FULL);
  endfunction

endpackage

// File: rtl/pfc_arm.sv
module pfc_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger_in,
  output logic fire,
  output logic done
);
  logic trig_q;
  logic fire_q;
  logic done_q;

  assign fire = trigger_in && !trig_q;
  assign done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      fire_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      trig_q <= trigger_in;
      fire_q <= fire;
      done_q <= fire_q;
    end
  end
endmodule

// File: rtl/pfc_mode_resolve.sv
module pfc_mode_resolve
  import pfc_pkg::*;
(
  input  logic       loc_pause,
  input  logic       loc_asym,
  input  logic       lp_pause,
  input  logic       lp_asym,
  input  logic       full_duplex,
  input  logic [2:0] req_mode,
  output fc_mode_e   mode
);
  always_comb begin
    mode = resolve_pause(loc_pause, loc_asym, lp_pause, lp_asym,
                         full_duplex, req_mode);
  end
endmodule

// File: rtl/pfc_thr_build.sv
module pfc_thr_build
  import pfc_pkg::*;
#(
  parameter int WATER_W = 16,
  parameter int THR_W   = 32
) (
  input  fc_mode_e           mode,
  input  logic [WATER_W-1:0] low_water,
  input  logic [WATER_W-1:0] high_water,
  input  logic               send_xon,
  output logic [THR_W-1:0]   low_word,
  output logic [THR_W-1:0]   high_word
);
  localparam int XON_POS = THR_W - 1;

  logic tx_on;
  assign tx_on = mode_has_tx(mode);

  always_comb begin
    low_word  = '0;
    high_word = '0;
    if (tx_on) begin
      low_word[WATER_W-1:0]  = low_water;
      low_word[XON_POS]      = send_xon;
      high_word[WATER_W-1:0] = high_water;
    end
  end
endmodule

// File: rtl/pause_fc_resolver.sv
module pause_fc_resolver
  import pfc_pkg::*;
#(
  parameter int WATER_W = 16,
  parameter int THR_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               an_done,
  input  logic               loc_pause,
  input  logic               loc_asym,
  input  logic               lp_pause,
  input  logic               lp_asym,
  input  logic               full_duplex,
  input  logic [2:0]         req_mode,
  input  logic [WATER_W-1:0] low_water,
  input  logic [WATER_W-1:0] high_water,
  input  logic               send_xon,
  output logic [1:0]         fc_mode,
  output logic               tx_pause_en,
  output logic               rx_pause_en,
  output logic [THR_W-1:0]   fc_low_thr,
  output logic [THR_W-1:0]   fc_high_thr,
  output logic               resolve_done
);
  // Named internal events for the checker
  logic             resolve_fire;
  fc_mode_e         mode_c;
  logic [THR_W-1:0] low_c;
  logic [THR_W-1:0] high_c;

  pfc_arm u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .trigger_in (an_done),
    .fire       (resolve_fire),
    .done       (resolve_done)
  );

  pfc_mode_resolve u_res (
    .loc_pause   (loc_pause),
    .loc_asym    (loc_asym),
    .lp_pause    (lp_pause),
    .lp_asym     (lp_asym),
    .full_duplex (full_duplex),
    .req_mode    (req_mode),
    .mode        (mode_c)
  );

  pfc_thr_build #(.WATER_W(WATER_W), .THR_W(THR_W)) u_thr (
    .mode       (mode_c),
    .low_water  (low_water),
    .high_water (high_water),
    .send_xon   (send_xon),
    .low_word   (low_c),
    .high_word  (high_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fc_mode     <= 2'd0;
      tx_pause_en <= 1'b0;
      rx_pause_en <= 1'b0;
      fc_low_thr  <= '0;
      fc_high_thr <= '0;
    end else if (resolve_fire) begin
      fc_mode     <= mode_c;
      tx_pause_en <= mode_has_tx(mode_c);
      rx_pause_en <= mode_has_rx(mode_c);
      fc_low_thr  <= low_c;
      fc_high_thr <= high_c;
    end
  end
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int THR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             resolve_fire,
  input logic             full_duplex,
  input logic [1:0]       fc_mode,
  input logic             tx_pause_en,
  input logic             rx_pause_en,
  input logic [THR_W-1:0] fc_low_thr,
  input logic [THR_W-1:0] fc_high_thr,
  input logic             resolve_done
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !resolve_fire |=> ($stable(fc_mode) && $stable(tx_pause_en) &&
                       $stable(rx_pause_en) && $stable(fc_low_thr) &&
                       $stable(fc_high_thr)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_fire |=> ##1 resolve_done);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_done |=> !resolve_done);

  assert_half_duplex_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_fire && !full_duplex) |=> (fc_mode == 2'd0));

  assert_enables_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pause_en == fc_mode[1]) && (rx_pause_en == fc_mode[0]));

  assert_thr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_pause_en |-> (fc_low_thr == '0 && fc_high_thr == '0));

  assert_xon_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fc_low_thr[THR_W-1] |-> tx_pause_en);
endmodule

bind pause_fc_resolver pfc_checker #(.THR_W(THR_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .resolve_fire (resolve_fire),
  .full_duplex  (full_duplex),
  .fc_mode      (fc_mode),
  .tx_pause_en  (tx_pause_en),
  .rx_pause_en  (rx_pause_en),
  .fc_low_thr   (fc_low_thr),
  .fc_high_thr  (fc_high_thr),
  .resolve_done (resolve_done)
);

// File: tb/pause_fc_resolver_tb_top.sv
module pause_fc_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        an_done = 1'b0;
  logic        loc_pause = 1'b0, loc_asym = 1'b0, lp_pause = 1'b0, lp_asym = 1'b0;
  logic        full_duplex = 1'b1;
  logic [2:0]  req_mode = 3'd0;
  logic [15:0] low_water = '0, high_water = '0;
  logic        send_xon = 1'b0;
  logic [1:0]  fc_mode;
  logic        tx_pause_en, rx_pause_en;
  logic [31:0] fc_low_thr, fc_high_thr;
  logic        resolve_done;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pause_fc_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .an_done(an_done),
    .loc_pause(loc_pause), .loc_asym(loc_asym),
    .lp_pause(lp_pause), .lp_asym(lp_asym),
    .full_duplex(full_duplex), .req_mode(req_mode),
    .low_water(low_water), .high_water(high_water), .send_xon(send_xon),
    .fc_mode(fc_mode), .tx_pause_en(tx_pause_en), .rx_pause_en(rx_pause_en),
    .fc_low_thr(fc_low_thr), .fc_high_thr(fc_high_thr),
    .resolve_done(resolve_done)
  );

  // {lp, la, rp, ra, fd, req[2:0], sx, expected mode[1:0]}
  localparam int NV = 18;
  localparam logic [10:0] VEC [NV] = '{
    11'b1_0_1_0_1_011_1_11,  // R2 both pause, full
    11'b1_1_1_1_1_100_0_11,  // R2 default 4 -> full
    11'b1_0_1_1_1_111_1_11,  // R2 default 7 -> full
    11'b1_1_1_0_1_001_1_01,  // R2 rx requested -> rx
    11'b1_0_1_0_1_000_0_01,  // R2 none requested -> rx
    11'b1_1_1_1_1_010_1_01,  // R2 tx requested -> rx
    11'b0_1_1_1_1_011_1_10,  // R3 tx only
    11'b0_1_1_1_1_000_0_10,  // R3 tx only, xon off
    11'b1_1_0_1_1_011_1_01,  // R4 rx only
    11'b0_0_1_1_1_011_1_00,  // R5
    11'b0_1_1_0_1_011_1_00,  // R5
    11'b0_1_0_1_1_011_1_00,  // R5
    11'b1_0_0_1_1_011_1_00,  // R5
    11'b1_1_0_0_1_011_1_00,  // R5
    11'b1_0_0_0_1_011_1_00,  // R5
    11'b0_0_0_0_1_011_1_00,  // R5
    11'b1_1_1_1_0_011_1_00,  // R6 half duplex, full abilities
    11'b0_1_1_1_0_011_1_00   // R6 half duplex, tx-only abilities
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_outputs(input string req, input logic [1:0] m,
                               input logic [15:0] lw, input logic [15:0] hw,
                               input logic sx);
    logic        txe, rxe;
    logic [31:0] el, eh;
    txe = (m == 2'd2) || (m == 2'd3);
    rxe = (m == 2'd1) || (m == 2'd3);
    el  = txe ? {sx, 15'd0, lw} : 32'd0;
    eh  = txe ? {16'd0, hw} : 32'd0;
    chk(req, "mode", {30'd0, fc_mode}, {30'd0, m});
    chk("R7", "tx_en", {31'd0, tx_pause_en}, {31'd0, txe});
    chk("R7", "rx_en", {31'd0, rx_pause_en}, {31'd0, rxe});
    chk("R9", "low_thr", fc_low_thr, el);
    chk("R8", "high_thr", fc_high_thr, eh);
  endtask

  // Raise an_done after one low cycle; returns at the negedge after the load edge.
  task automatic fire_resolve();
    an_done = 1'b0;
    @(negedge clk);
    an_done = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "mode", {30'd0, fc_mode}, 32'd0);
    chk("R1", "low_thr", fc_low_thr, 32'd0);
    chk("R1", "high_thr", fc_high_thr, 32'd0);
    chk("R1", "enables", {30'd0, tx_pause_en, rx_pause_en}, 32'd0);
    chk("R1", "done", {31'd0, resolve_done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      automatic logic [10:0] v = VEC[i];
      automatic logic [15:0] lw = 16'(16'h0100 + i * 273);
      automatic logic [15:0] hw = 16'(16'h2000 + i * 4369);
      {loc_pause, loc_asym, lp_pause, lp_asym, full_duplex} = v[10:6];
      req_mode   = v[5:3];
      send_xon   = v[2];
      low_water  = lw;
      high_water = hw;
      fire_resolve();
      check_outputs(v[1:0] == 2'd2 ? "R3" :
                    (v[6] == 1'b0 ? "R6" : "R2"), v[1:0], lw, hw, v[2]);
      chk("R11", "done_same_cycle", {31'd0, resolve_done}, 32'd0);
      @(negedge clk);
      chk("R11", "done_pulse", {31'd0, resolve_done}, 32'd1);
      @(negedge clk);
      chk("R11", "done_drop", {31'd0, resolve_done}, 32'd0);
    end

    // R4 and R10: resolve rx-only, then change inputs while an_done held high
    {loc_pause, loc_asym, lp_pause, lp_asym, full_duplex} = 5'b11011;
    req_mode = 3'd3; send_xon = 1'b1; low_water = 16'h0abc; high_water = 16'h0def;
    fire_resolve();
    check_outputs("R4", 2'd1, 16'h0abc, 16'h0def, 1'b1);
    {loc_pause, loc_asym, lp_pause, lp_asym} = 4'b0111;
    low_water = 16'h1111;
    repeat (4) @(negedge clk);
    check_outputs("R10", 2'd1, 16'h0abc, 16'h0def, 1'b1);
    chk("R10", "no_redone", {31'd0, resolve_done}, 32'd0);
    an_done = 1'b0;
    repeat (3) @(negedge clk);
    check_outputs("R10", 2'd1, 16'h0abc, 16'h0def, 1'b1);

    // New edge picks up the changed inputs: tx-only with xon off
    send_xon = 1'b0;
    fire_resolve();
    check_outputs("R3", 2'd2, 16'h1111, 16'h0def, 1'b0);

    // Full with XON, then half duplex zeroes everything
    {loc_pause, loc_asym, lp_pause, lp_asym, full_duplex} = 5'b10101;
    send_xon = 1'b1; low_water = 16'hffff; high_water = 16'hfffe;
    fire_resolve();
    check_outputs("R9", 2'd3, 16'hffff, 16'hfffe, 1'b1);
    full_duplex = 1'b0;
    fire_resolve();
    check_outputs("R6", 2'd0, 16'hffff, 16'hfffe, 1'b1);

    // Reset in the middle clears resolved state
    full_duplex = 1'b1;
    fire_resolve();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "mode_after_rst", {30'd0, fc_mode}, 32'd0);
    chk("R1", "low_after_rst", fc_low_thr, 32'd0);
    rst_n = 1'b1;
    an_done = 1'b0;
    repeat (2) @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule